// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is a synchronous supervisor. It turns a few digital status inputs into a processor reset and a watchdog status flag. An external threshold comparator supplies a supply-good flag. Whenever that flag is low, the block holds the processor in reset and lowers a line-status flag. Once the supply returns, reset is stretched for a fixed active period, and a watchdog then watches a toggling input from the processor. If that input stops changing for longer than the timeout, the block issues a full reset pulse and latches the watchdog status low until the next toggle.

Time is counted in ticks from one of two sources. In internal mode, a parameterized prescaler produces one tick per millisecond of the system clock. The active period is 200 ticks, and the watchdog timeout is 100 or 1600 ticks, chosen by a select input. In external mode, each cycle in which an external clock enable is high counts as one tick. The periods are then 2048 ticks for the reset pulse, 1024 for the normal timeout and 4096 for the long timeout. The first timeout after any reset always uses the long period, so a processor that has just been restarted gets extra time to recover.

Top module: `sup_rst_wdog`

## Requirements
- R1: While `supply_ok` is 0, `reset_n_o` is 0 in the same cycle, without waiting for a clock edge. `line_ok_o` always equals `supply_ok`.
- R2: After `supply_ok` rises, `reset_n_o` stays 0 for the active period and then goes to 1. The active period is 200 ticks in internal mode (`ext_mode`=0) and 2048 ticks in external mode (`ext_mode`=1).
- R3: Outside the first period after a reset, the watchdog timeout is the normal period. In internal mode this is 100 ticks when `short_sel`=1 and 1600 ticks when `short_sel`=0. In external mode it is 1024 ticks.
- R4: The first timeout after a reset ends is the long period, even when the short period is selected. This is 1600 ticks in internal mode and 4096 ticks in external mode. The normal period applies only after the first `wd_in` edge that follows the reset.
- R5: `wd_in` passes through a two-flop synchronizer. Each rising or falling edge is counted once and restarts the watchdog count. Edges that arrive while reset is active are discarded, and the count restarts when reset ends. If `wd_in` toggles at intervals shorter than the timeout, no reset occurs.
- R6: A timeout starts a full active-period reset pulse and drives `wd_stat_n` to 0. `wd_stat_n` stays 0 until the next counted `wd_in` edge, which sets it back to 1.
- R7: If `wd_in` never toggles, reset pulses repeat. Each pulse begins one long period after the previous pulse ended.
- R8: While `supply_ok` is 0, `wd_stat_n` is forced to 1 and the watchdog is stopped. While `wd_off`=1, `wd_in` is ignored and no timeout occurs.
- R9: `reset_o` is always the exact complement of `reset_n_o`.
- R10: In internal mode, one tick occurs every `MS_CYCLES` system clock cycles. In external mode, one tick occurs in each cycle in which `ext_tick`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's own flops |
| supply_ok | input | 1 | Supply-good flag from the external threshold comparator |
| wd_in | input | 1 | Watchdog input toggled by the processor (asynchronous) |
| wd_off | input | 1 | 1 disables the watchdog (stands in for a floating input) |
| ext_mode | input | 1 | 0 = internal ms timebase, 1 = external tick timebase |
| short_sel | input | 1 | Internal mode: 1 = short normal timeout, 0 = long |
| ext_tick | input | 1 | External clock enable, one tick per high cycle |
| reset_n_o | output | 1 | Active-low processor reset |
| reset_o | output | 1 | Active-high processor reset |
| wd_stat_n | output | 1 | Watchdog status, 0 after a timeout until the next edge |
| line_ok_o | output | 1 | Low-line flag, 0 while the supply is below threshold |

## Verification
The watchdog is driven with three input patterns in both timebases: held steady, toggled once, and toggled regularly. A steady input separates the long first period from the normal period and shows that pulses repeat. A single toggle shows that the short period takes effect and that `wd_stat_n` is released. Regular toggling shows that the count restarts on every edge. A drop of the supply while the status is latched low, and a long run with `wd_off` set, check the forcing and disabling paths. Pulse lengths are measured in clock cycles, with windows that allow for one tick of prescaler phase and the synchronizer delay.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Number of ticks in the reset active period for the selected timebase.
  function automatic int unsigned rst_ticks(input logic ext,
                                            input int unsigned int_ticks,
                                            input int unsigned ext_ticks);
    return ext ? ext_ticks : int_ticks;
  endfunction

  // Number of ticks in the watchdog timeout for the selected timebase and phase.
  function automatic int unsigned wd_ticks(input logic ext,
                                           input logic long_ph,
                                           input logic short_sel,
                                           input int unsigned s_ticks,
                                           input int unsigned l_ticks,
                                           input int unsigned en_ticks,
                                           input int unsigned el_ticks);
    if (ext) return long_ph ? el_ticks : en_ticks;
    return (long_ph || !short_sel) ? l_ticks : s_ticks;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
  parameter int unsigned MS_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic ext_tick,
  output logic tick_o
);
  logic int_tick;

  generate
    if (MS_CYCLES < 2) begin : g_direct
      assign int_tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(MS_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(MS_CYCLES - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
      end
      assign int_tick = (pcnt == LAST);

      // R10: the internal ticks are spaced by the prescaler, never back to back
      assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick);
    end
  endgenerate

  assign tick_o = ext_mode ? ext_tick : int_tick;
endmodule

// File: rtl/sup_edge_det.sv
module sup_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic tog_o
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], d_i};
  end

  // One pulse per change of the synchronized level
  assign tog_o = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/sup_rst_ctl.sv
module sup_rst_ctl
  import sup_pkg::*;
#(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned RST_MS  = 200,
  parameter int unsigned EXT_RST = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic tick,
  input  logic ext_mode,
  input  logic wd_fire,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             rst_end;

  assign last    = CNT_W'(rst_ticks(ext_mode, RST_MS, EXT_RST) - 1);
  assign rst_end = busy_o & supply_ok & tick & (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b1;
      cnt    <= '0;
    end else if (!supply_ok) begin
      busy_o <= 1'b1;
      cnt    <= '0;
    end else if (wd_fire && !busy_o) begin
      busy_o <= 1'b1;
      cnt    <= '0;
    end else if (rst_end) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (busy_o && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: a low supply always leaves the stretcher busy
  assert_supply_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> busy_o);
  // R2: reset only ends on a tick with a good supply
  assert_release_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(tick) && $past(supply_ok)));
  // R6: a timeout outside reset starts a new pulse
  assert_fire_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && !busy_o) |=> busy_o);
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_pkg::*;
#(
  parameter int unsigned CNT_W    = 13,
  parameter int unsigned SHORT_MS = 100,
  parameter int unsigned LONG_MS  = 1600,
  parameter int unsigned EXT_NORM = 1024,
  parameter int unsigned EXT_LONG = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_off,
  input  logic tog_i,
  input  logic tick,
  input  logic busy,
  input  logic ext_mode,
  input  logic short_sel,
  output logic fire_o,
  output logic wd_n_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             long_q;
  logic             run;

  assign run    = supply_ok & ~wd_off & ~busy;
  assign lim    = CNT_W'(wd_ticks(ext_mode, long_q, short_sel,
                                  SHORT_MS, LONG_MS, EXT_NORM, EXT_LONG) - 1);
  assign fire_o = run & ~tog_i & tick & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      long_q <= 1'b1;
      wd_n_o <= 1'b1;
    end else if (!supply_ok) begin
      cnt    <= '0;
      long_q <= 1'b1;
      wd_n_o <= 1'b1;
    end else if (busy) begin
      cnt    <= '0;
      long_q <= 1'b1;
    end else if (wd_off) begin
      cnt <= '0;
    end else if (tog_i) begin
      cnt    <= '0;
      long_q <= 1'b0;
      wd_n_o <= 1'b1;
    end else if (tick) begin
      if (cnt == lim) begin
        cnt    <= '0;
        wd_n_o <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: a timeout latches the status low
  assert_fire_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !wd_n_o);
  // R6: a counted edge releases the status
  assert_edge_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_i && run) |=> wd_n_o);
  // R8: a low supply forces the status high
  assert_supply_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> wd_n_o);
  // R4: the period right after reset is the long one
  assert_long_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && supply_ok) |-> long_q);
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
  import sup_pkg::*;
#(
  parameter int unsigned MS_CYCLES = 50000,
  parameter int unsigned RST_MS    = 200,
  parameter int unsigned SHORT_MS  = 100,
  parameter int unsigned LONG_MS   = 1600,
  parameter int unsigned EXT_RST   = 2048,
  parameter int unsigned EXT_NORM  = 1024,
  parameter int unsigned EXT_LONG  = 4096,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_in,
  input  logic wd_off,
  input  logic ext_mode,
  input  logic short_sel,
  input  logic ext_tick,
  output logic reset_n_o,
  output logic reset_o,
  output logic wd_stat_n,
  output logic line_ok_o
);
  localparam int unsigned MAX_T = max_of(max_of(max_of(RST_MS, LONG_MS), SHORT_MS),
                                         max_of(max_of(EXT_RST, EXT_LONG), EXT_NORM));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  // Named internal events
  logic tick;
  logic wd_tog;
  logic wd_fire;
  logic busy;

  sup_tick_gen #(.MS_CYCLES(MS_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ext_tick(ext_tick), .tick_o(tick)
  );

  sup_edge_det #(.STAGES(SYNC_STG)) u_edge (
    .clk(clk), .rst_n(rst_n), .d_i(wd_in), .tog_o(wd_tog)
  );

  sup_rst_ctl #(.CNT_W(CNT_W), .RST_MS(RST_MS), .EXT_RST(EXT_RST)) u_rst (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
    .ext_mode(ext_mode), .wd_fire(wd_fire), .busy_o(busy)
  );

  sup_wd_timer #(.CNT_W(CNT_W), .SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS),
                 .EXT_NORM(EXT_NORM), .EXT_LONG(EXT_LONG)) u_wd (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_off(wd_off),
    .tog_i(wd_tog), .tick(tick), .busy(busy), .ext_mode(ext_mode),
    .short_sel(short_sel), .fire_o(wd_fire), .wd_n_o(wd_stat_n)
  );

  assign reset_n_o = supply_ok & ~busy;
  assign reset_o   = ~reset_n_o;
  assign line_ok_o = supply_ok;

  // R8: no timeout while disabled
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> !$fell(wd_stat_n));
endmodule

// File: tb/tb_sup_rst_wdog.sv
`timescale 1ns/1ps
module tb_sup_rst_wdog;
  localparam int P = 2; // prescaler cycles per tick

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, wd_in = 0, wd_off = 0, ext_mode = 0, short_sel = 0, ext_tick = 0;
  logic reset_n_o, reset_o, wd_stat_n, line_ok_o;

  int checks = 0, failures = 0, comp_bad = 0;

  sup_rst_wdog #(.MS_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_in(wd_in), .wd_off(wd_off),
    .ext_mode(ext_mode), .short_sel(short_sel), .ext_tick(ext_tick),
    .reset_n_o(reset_n_o), .reset_o(reset_o), .wd_stat_n(wd_stat_n), .line_ok_o(line_ok_o)
  );

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
    if (reset_o !== ~reset_n_o) comp_bad++;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_win(input string req, input string what, input int act,
                           input int lo, input int hi);
    check(act >= lo && act <= hi, req, what, act, lo);
  endtask

  // Steps until reset_n_o equals lvl, capped at lim
  task automatic wait_rst(input logic lvl, input int lim, output int n);
    n = 0;
    while (reset_n_o !== lvl && n < lim) begin step(); n++; end
  endtask

  task automatic t_reset_state();
    repeat (3) step();
    rst_n = 1; step();
    check(reset_n_o === 1'b0, "R1", "reset_n_o at reset", reset_n_o, 0);
    check(line_ok_o === 1'b0, "R1", "line_ok_o at reset", line_ok_o, 0);
    check(wd_stat_n === 1'b1, "R8", "wd_stat_n at reset", wd_stat_n, 1);
  endtask

  task automatic t_power_up_int();
    int n;
    short_sel = 1;
    supply_ok = 1; #1;
    check(line_ok_o === 1'b1, "R1", "line_ok_o follows supply", line_ok_o, 1);
    wait_rst(1, 1000, n);
    check_win("R2", "internal active period cycles", n, 200*P-3, 200*P+3);
  endtask

  task automatic t_stuck_int();
    int n;
    wait_rst(0, 5000, n);
    check_win("R4", "first timeout long despite short select", n, 1600*P-4, 1600*P+4);
    check(wd_stat_n === 1'b0, "R6", "wd_stat_n low after timeout", wd_stat_n, 0);
    wait_rst(1, 1000, n);
    check_win("R6", "timeout pulse length", n, 200*P-3, 200*P+3);
    wait_rst(0, 5000, n);
    check_win("R7", "repeat pulse after long period", n, 1600*P-4, 1600*P+4);
    wait_rst(1, 1000, n);
  endtask

  task automatic t_short_after_edge();
    int n;
    wd_in = ~wd_in;
    repeat (5) step();
    check(wd_stat_n === 1'b1, "R6", "edge releases wd_stat_n", wd_stat_n, 1);
    wait_rst(0, 5000, n);
    check_win("R3", "short timeout from edge", n + 5, 100*P, 100*P+8);
    wait_rst(1, 1000, n);
  endtask

  task automatic t_keepalive();
    int resets = 0;
    for (int i = 0; i < 20; i++) begin
      wd_in = ~wd_in;
      for (int j = 0; j < 150; j++) begin
        step();
        if (reset_n_o !== 1'b1) resets++;
      end
    end
    check(resets == 0, "R5", "regular toggling keeps reset off", resets, 0);
  endtask

  task automatic t_long_sel_and_drop();
    int n;
    short_sel = 0;
    wd_in = ~wd_in;
    wait_rst(0, 5000, n);
    check_win("R3", "long normal timeout (short_sel=0)", n, 1600*P, 1600*P+8);
    check(wd_stat_n === 1'b0, "R6", "wd_stat_n low before drop", wd_stat_n, 0);
    step();
    supply_ok = 0; #1;
    check(reset_n_o === 1'b0, "R1", "reset_n_o with supply low", reset_n_o, 0);
    check(line_ok_o === 1'b0, "R1", "line_ok_o with supply low", line_ok_o, 0);
    step();
    check(wd_stat_n === 1'b1, "R8", "wd_stat_n forced high on low supply", wd_stat_n, 1);
    repeat (4) step();
    supply_ok = 1;
    wait_rst(1, 1000, n);
  endtask

  task automatic t_disabled();
    int resets = 0;
    wd_off = 1;
    for (int i = 0; i < 5000; i++) begin
      step();
      if (reset_n_o !== 1'b1) resets++;
    end
    check(resets == 0, "R8", "no timeout while disabled", resets, 0);
    check(wd_stat_n === 1'b1, "R8", "wd_stat_n high while disabled", wd_stat_n, 1);
    wd_off = 0;
  endtask

  task automatic t_external();
    int n;
    supply_ok = 0; ext_mode = 1; ext_tick = 1;
    step(); step();
    supply_ok = 1;
    wait_rst(1, 5000, n);
    check_win("R10", "external active period (2048 ticks)", n, 2046, 2050);
    wait_rst(0, 9000, n);
    check_win("R4", "external first timeout long", n, 4093, 4099);
    wait_rst(1, 5000, n);
    check_win("R2", "external timeout pulse length", n, 2046, 2050);
    wd_in = ~wd_in;
    wait_rst(0, 5000, n);
    check_win("R3", "external normal timeout", n, 1024, 1030);
  endtask

  initial begin
    #1000000;
    failures++; checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_power_up_int();
    t_stuck_int();
    t_short_after_edge();
    t_keepalive();
    t_long_sel_and_drop();
    t_disabled();
    t_external();
    check(comp_bad == 0, "R9", "reset_o complement mismatches", comp_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule